// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide execution unit of a 32-bit load-store RISC core. It keeps its own pair of result registers, HI and LO, apart from the general register file. An operation code and two register operands are offered together with a valid strobe. The unit accepts the operation when it is idle.

Multiplication, signed or unsigned, finishes in the cycle of acceptance. The 64-bit product is split across HI (upper half) and LO (lower half). Division, signed or unsigned, runs as a radix-2 restoring iteration, one quotient bit per clock. The quotient goes to LO and the remainder to HI. Two further operations load HI or LO from an operand. Two more return HI or LO on a registered read port.

While a division runs, the unit holds its ready output low. A read request that arrives in that window stays pending until the division has written both registers. The core therefore never reads a half-finished result.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 (signed multiply) writes the 64-bit two's-complement product of op_a and op_b, upper half into HI and lower half into LO, at the acceptance edge.
- R2: Operation code 1 (unsigned multiply) writes the 64-bit product of op_a and op_b taken as unsigned values, upper half into HI and lower half into LO.
- R3: A multiply never raises busy. A divide raises busy from the edge that accepts it for exactly XLEN clock cycles (32 by default).
- R4: Operation code 2 (signed divide) writes to LO the quotient truncated toward zero and to HI the remainder carrying the sign of the dividend. The case 0x80000000 divided by -1 gives LO 0x80000000 and HI 0.
- R5: Operation code 3 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: A divide by zero, signed or unsigned, writes all ones to LO and the unmodified dividend to HI.
- R7: Operation code 4 loads HI from op_a and code 5 loads LO from op_a; the other register keeps its value.
- R8: Operation code 6 (read HI) or 7 (read LO), once accepted, gives rd_valid high for one cycle after the acceptance edge, with rd_data holding the register value.
- R9: op_ready is low while busy is high, and no operation is accepted then. A read held pending through a divide returns that divide's result.
- R10: After reset, busy and rd_valid are low, op_ready is high, and HI and LO read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation code (see requirements) |
| op_a | input | XLEN | First operand / value for HI or LO load |
| op_b | input | XLEN | Second operand (multiplier or divisor) |
| op_ready | output | 1 | Unit accepts an offered operation |
| busy | output | 1 | Divide iteration in progress |
| rd_valid | output | 1 | Read result present |
| rd_data | output | XLEN | Value of HI or LO returned by a read |

## Verification
The bench builds the unit with XLEN at its default of 32, so the divider runs its full 32-step iteration and the busy window can be counted exactly. At this width the operand corners are reachable directly: the most negative value, minus one, all ones and zero divisors. The bench models products and quotients with native 64-bit and 32-bit arithmetic. Random operation mixes also exercise back-to-back register loads and reads around divides.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_SET_HI = 3'd4,
        OP_SET_LO = 3'd5,
        OP_GET_HI = 3'd6,
        OP_GET_LO = 3'd7
    } md_op_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   mul_a,
    input  logic [XLEN-1:0]   mul_b,
    input  logic              mul_signed,
    output logic [2*XLEN-1:0] mul_prod
);
    localparam int PW = 2 * XLEN;

    logic           a_ext;
    logic           b_ext;
    logic [PW-1:0]  a_wide;
    logic [PW-1:0]  b_wide;

    // Extending both operands to full product width makes the low PW bits
    // of the product correct for signed and unsigned operands alike.
    always_comb begin
        a_ext    = mul_signed & mul_a[XLEN-1];
        b_ext    = mul_signed & mul_b[XLEN-1];
        a_wide   = {{XLEN{a_ext}}, mul_a};
        b_wide   = {{XLEN{b_ext}}, mul_b};
        mul_prod = a_wide * b_wide;
    end

endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] part_rem,
    input  logic [XLEN-1:0] part_quo,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] next_rem,
    output logic [XLEN-1:0] next_quo
);
    logic [XLEN:0] shifted;
    logic [XLEN:0] trial;
    logic          fits;

    always_comb begin
        shifted  = {part_rem, part_quo[XLEN-1]};
        trial    = shifted - {1'b0, divisor};
        fits     = ~trial[XLEN];
        next_rem = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        next_quo = {part_quo[XLEN-2:0], fits};
    end

endmodule

// File: rtl/muldiv_div_fix.sv
module muldiv_div_fix #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] mag_quo,
    input  logic [XLEN-1:0] mag_rem,
    input  logic            flip_quo,
    input  logic            flip_rem,
    input  logic            by_zero,
    input  logic [XLEN-1:0] dividend,
    output logic [XLEN-1:0] fin_quo,
    output logic [XLEN-1:0] fin_rem
);
    always_comb begin
        if (by_zero) begin
            fin_quo = '1;
            fin_rem = dividend;
        end else begin
            fin_quo = flip_quo ? (~mag_quo + 1'b1) : mag_quo;
            fin_rem = flip_rem ? (~mag_rem + 1'b1) : mag_rem;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            op_ready,
    output logic            busy,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_data
);
    import muldiv_pkg::*;

    localparam int CNT_W = $clog2(XLEN + 1);

    typedef struct packed {
        logic [XLEN-1:0]  hi;
        logic [XLEN-1:0]  lo;
        logic [XLEN-1:0]  rem;
        logic [XLEN-1:0]  quo;
        logic [XLEN-1:0]  dvs;
        logic [XLEN-1:0]  dvd;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             neg_q;
        logic             neg_r;
        logic             dz;
        logic             rd_valid;
        logic [XLEN-1:0]  rd_data;
    } md_state_t;

    md_state_t s_d, s_q;

    md_op_e            op_e;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   step_rem, step_quo;
    logic [XLEN-1:0]   fin_quo, fin_rem;
    logic              neg_a, neg_b;
    logic [XLEN-1:0]   mag_a, mag_b;

    assign op_e = md_op_e'(op_code);

    muldiv_mul #(.XLEN(XLEN)) u_mul (
        .mul_a      (op_a),
        .mul_b      (op_b),
        .mul_signed (op_e == OP_MUL_S),
        .mul_prod   (prod)
    );

    muldiv_div_step #(.XLEN(XLEN)) u_step (
        .part_rem (s_q.rem),
        .part_quo (s_q.quo),
        .divisor  (s_q.dvs),
        .next_rem (step_rem),
        .next_quo (step_quo)
    );

    muldiv_div_fix #(.XLEN(XLEN)) u_fix (
        .mag_quo  (step_quo),
        .mag_rem  (step_rem),
        .flip_quo (s_q.neg_q),
        .flip_rem (s_q.neg_r),
        .by_zero  (s_q.dz),
        .dividend (s_q.dvd),
        .fin_quo  (fin_quo),
        .fin_rem  (fin_rem)
    );

    always_comb begin
        neg_a = (op_e == OP_DIV_S) & op_a[XLEN-1];
        neg_b = (op_e == OP_DIV_S) & op_b[XLEN-1];
        mag_a = neg_a ? (~op_a + 1'b1) : op_a;
        mag_b = neg_b ? (~op_b + 1'b1) : op_b;

        s_d          = s_q;
        s_d.rd_valid = 1'b0;

        if (s_q.busy) begin
            s_d.rem = step_rem;
            s_d.quo = step_quo;
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.lo   = fin_quo;
                s_d.hi   = fin_rem;
            end
        end else if (op_valid) begin
            unique case (op_e)
                OP_MUL_S, OP_MUL_U: begin
                    s_d.hi = prod[2*XLEN-1:XLEN];
                    s_d.lo = prod[XLEN-1:0];
                end
                OP_DIV_S, OP_DIV_U: begin
                    s_d.rem   = '0;
                    s_d.quo   = mag_a;
                    s_d.dvs   = mag_b;
                    s_d.dvd   = op_a;
                    s_d.cnt   = CNT_W'(XLEN);
                    s_d.busy  = 1'b1;
                    s_d.neg_q = neg_a ^ neg_b;
                    s_d.neg_r = neg_a;
                    s_d.dz    = (op_b == '0);
                end
                OP_SET_HI: s_d.hi = op_a;
                OP_SET_LO: s_d.lo = op_a;
                OP_GET_HI: begin
                    s_d.rd_valid = 1'b1;
                    s_d.rd_data  = s_q.hi;
                end
                OP_GET_LO: begin
                    s_d.rd_valid = 1'b1;
                    s_d.rd_data  = s_q.lo;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_ready = ~s_q.busy;
    assign busy     = s_q.busy;
    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [XLEN-1:0] op_a,
    input logic            op_ready,
    input logic            busy,
    input logic            rd_valid,
    input logic [XLEN-1:0] hi_q,
    input logic [XLEN-1:0] lo_q
);
    localparam int CW = $clog2(XLEN + 1);

    logic [CW-1:0] busy_run;
    logic          take;

    assign take = op_valid && op_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    AST_MUL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_code[2:1] == 2'b00) |=> !busy); // R3
    AST_DIV_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_code[2:1] == 2'b01) |=> busy); // R3
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < CW'(XLEN)); // R3
    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid); // R9
    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_code[2:1] == 2'b11) |=> rd_valid); // R8
    AST_SET_HI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_code == 3'd4) |=> (hi_q == $past(op_a)) && $stable(lo_q)); // R7
    AST_SET_LO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_code == 3'd5) |=> (lo_q == $past(op_a)) && $stable(hi_q)); // R7

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_a     (op_a),
    .op_ready (op_ready),
    .busy     (busy),
    .rd_valid (rd_valid),
    .hi_q     (s_q.hi),
    .lo_q     (s_q.lo)
);

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [2:0]      op_code = 3'd0;
    logic [XLEN-1:0] op_a = '0;
    logic [XLEN-1:0] op_b = '0;
    logic            op_ready, busy, rd_valid;
    logic [XLEN-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    always #5 clk = ~clk;

    muldiv_unit #(.XLEN(XLEN)) u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .op_ready(op_ready), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sp;
        logic [63:0] up;
        int sa, sb;
        sa = $signed(a);
        sb = $signed(b);
        case (op)
            3'd0: begin sp = longint'(sa) * longint'(sb); {m_hi, m_lo} = sp; end
            3'd1: begin up = {32'd0, a} * {32'd0, b}; {m_hi, m_lo} = up; end
            3'd2: begin
                if (b == 0) begin m_lo = '1; m_hi = a; end
                else if (a == 32'h8000_0000 && sb == -1) begin m_lo = a; m_hi = 0; end
                else begin m_lo = sa / sb; m_hi = sa % sb; end
            end
            3'd3: begin
                if (b == 0) begin m_lo = '1; m_hi = a; end
                else begin m_lo = a / b; m_hi = a % b; end
            end
            3'd4: m_hi = a;
            3'd5: m_lo = a;
            default: ;
        endcase
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask

    task automatic read_check(input string req);
        send(3'd6, '0, '0);
        chk({req, " rd_valid HI"}, {63'd0, rd_valid}, 64'd1);
        chk({req, " HI"}, {32'd0, rd_data}, {32'd0, m_hi});
        send(3'd7, '0, '0);
        chk({req, " rd_valid LO"}, {63'd0, rd_valid}, 64'd1);
        chk({req, " LO"}, {32'd0, rd_data}, {32'd0, m_lo});
    endtask

    task automatic run_op(input string req, input logic [2:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        send(op, a, b);
        model(op, a, b);
        wait_idle();
        read_check(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int bcount;
        bit held_seen;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 busy", {63'd0, busy}, 64'd0);
        chk("R10 op_ready", {63'd0, op_ready}, 64'd1);
        chk("R10 rd_valid", {63'd0, rd_valid}, 64'd0);
        read_check("R10 R8");

        // R1 signed multiply, R3 no busy for multiply
        send(3'd0, 32'hFFFF_FFFD, 32'd7);
        chk("R3 mul busy", {63'd0, busy}, 64'd0);
        model(3'd0, 32'hFFFF_FFFD, 32'd7);
        read_check("R1 -3*7");
        run_op("R1 minint^2", 3'd0, 32'h8000_0000, 32'h8000_0000);
        // R2 unsigned multiply
        run_op("R2 ones^2", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R2 mixed", 3'd1, 32'h8000_0001, 32'd3);

        // R4 signed divide
        run_op("R4 -7/2", 3'd2, 32'hFFFF_FFF9, 32'd2);
        run_op("R4 7/-2", 3'd2, 32'd7, 32'hFFFF_FFFE);
        run_op("R4 minint/-1", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
        // R5 unsigned divide
        run_op("R5 big/7", 3'd3, 32'hFFFF_FFF0, 32'd7);
        run_op("R5 small/big", 3'd3, 32'd5, 32'hF000_0000);
        // R6 divide by zero
        run_op("R6 signed", 3'd2, 32'hFFFF_FFFB, 32'd0);
        run_op("R6 unsigned", 3'd3, 32'h1234_5678, 32'd0);

        // R3 busy window length
        send(3'd3, 32'd1000, 32'd3);
        model(3'd3, 32'd1000, 32'd3);
        bcount = 0;
        while (busy) begin bcount++; @(negedge clk); end
        chk("R3 busy cycles", 64'(bcount), 64'd32);

        // R9 read held off during divide
        send(3'd2, 32'hFFFF_FC18, 32'd9);
        model(3'd2, 32'hFFFF_FC18, 32'd9);
        op_valid = 1'b1; op_code = 3'd7;
        chk("R9 not ready while busy", {63'd0, op_ready}, 64'd0);
        held_seen = 1'b0;
        while (!op_ready) begin
            if (rd_valid) held_seen = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 no early answer", {63'd0, held_seen}, 64'd0);
        chk("R9 held read valid", {63'd0, rd_valid}, 64'd1);
        chk("R9 held read LO", {32'd0, rd_data}, {32'd0, m_lo});

        // R7 register loads
        run_op("R7 set HI", 3'd4, 32'hCAFE_0001, 32'd0);
        run_op("R7 set LO", 3'd5, 32'h0BAD_F00D, 32'd0);

        // mixed random stimulus
        for (int i = 0; i < 200; i++) begin
            logic [2:0] op;
            logic [31:0] a, b;
            op = 3'($urandom_range(0, 5));
            a = $urandom();
            b = $urandom();
            if ($urandom_range(0, 9) == 0) b = 32'd0;
            if ($urandom_range(0, 9) == 0) a = 32'h8000_0000;
            if ($urandom_range(0, 9) == 0) b = 32'hFFFF_FFFF;
            if ($urandom_range(0, 3) == 0) b = b >> $urandom_range(1, 31);
            case (op)
                3'd0: run_op("R1 random", op, a, b);
                3'd1: run_op("R2 random", op, a, b);
                3'd2: run_op("R4 R6 random", op, a, b);
                3'd3: run_op("R5 R6 random", op, a, b);
                default: run_op("R7 random", op, a, b);
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule